// File: doc/BRIEF.md
# I2C Register-Pair Port Expander Slave

This block is an I2C slave placed in front of eight byte-wide registers grouped as four 16-bit pairs. Two bytes mirror external input pins, and the other six are plain read/write storage for output values, polarity settings and direction settings. A master addresses the block with a 7-bit address made of a fixed upper nibble and three strap pins. The first byte of a write transfer is a command byte that loads the register pointer. Data bytes then go to, or come from, the register that the pointer selects. After each byte the pointer moves to the other half of the same pair.

The bus is open-drain. The block samples SCL and SDA and can only pull SDA low. All logic runs in one system clock domain, which must be several times faster than SCL. START and STOP are detected from the synchronized samples. The pointer always names the register being accessed at that moment, so a repeated START or a STOP leaves it there. A later read that has no command byte resumes from that register.

Top module: `i2c_pair_expander`

## Requirements
- R1: The block answers only to the address made of 0100 followed by `addr_strap[2:0]`, with the R/W bit last (0 write, 1 read). On a match it pulls SDA low for the ninth clock. On a mismatch it never drives SDA until the next START.
- R2: The command byte is acknowledged, and its low three bits load the pointer: 0/1 input ports, 2/3 output bytes, 4/5 polarity bytes, 6/7 direction bytes (the odd value is the upper byte). Bits 7:3 are ignored.
- R3: Each data byte written after the command byte is acknowledged. It lands in the register the pointer selects, and then bit 0 of the pointer flips.
- R4: Writes aimed at pointer 0 or 1 change no register, but the pointer still flips.
- R5: A read returns the selected register first and then alternates between the two halves of the pair for as many bytes as the master acknowledges.
- R6: An input-port byte carries the pin value sampled at the rising SCL edge of the acknowledge clock just before that byte. Pin changes during the byte do not affect it.
- R7: When the master does not acknowledge a read byte, the block releases SDA and ignores all clocks until the next START.
- R8: A repeated START leaves the pointer on the register being accessed at that moment. The command value written earlier is lost, and a following read without a command byte starts from that register.
- R9: A STOP ends a transfer at any bit. Bytes acknowledged before it stay written, and a partial byte is discarded.
- R10: After reset, SDA is released, the output and direction bytes read 0xFF, and the polarity bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_o | output | 1 | SDA drive value, always low |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_strap | input | 3 | Low three address bits |
| in_port0 | input | 8 | Input pins, register 0 |
| in_port1 | input | 8 | Input pins, register 1 |
| out_reg | output | 16 | Output bytes {reg 3, reg 2} |
| pol_reg | output | 16 | Polarity bytes {reg 5, reg 4} |
| cfg_reg | output | 16 | Direction bytes {reg 7, reg 6} |

## Verification
Two events can fall in the same system clock. At the end of a written data byte, the register write and the pointer flip happen together. At the master acknowledge of a read, the pointer flip and the load of the next byte from the partner register happen together. Multi-byte writes and reads that start from both even and odd command values provoke both cases, and random transfers add more. A bench model applies "use the current pointer, then flip it" and judges the result from the register outputs and the bytes read back. A read following a repeated START, with no command byte, shows where the pointer was left.

// File: rtl/exp_pkg.sv
// Shared types and constants for the register-pair expander.
// Assumes byte-wide registers and a pointer that selects one byte.
package exp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK
    } link_state_e;

endpackage

// File: rtl/exp_bus_sync.sv
// Synchronizes SCL/SDA into the system clock and flags SCL edges and
// START/STOP. Assumes the system clock is much faster than SCL, so both
// lines are seen stable for several samples around each change.
module exp_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_pipe;
    logic [DEPTH-1:0] sda_pipe;
    logic             scl_prev;
    logic             sda_prev;

    // Shift both lines through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
        end
    end

    assign scl_s    = scl_pipe[DEPTH-2];
    assign sda_s    = sda_pipe[DEPTH-2];
    assign scl_prev = scl_pipe[DEPTH-1];
    assign sda_prev = sda_pipe[DEPTH-1];

    // Edge and bus-condition flags from current versus previous sample.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/exp_regfile.sv
// Holds the register pointer and the writable bytes. Bytes 0 and 1 are
// the live input pins; the rest are storage. Assumes a pointer load and
// a toggle never come in the same cycle; the load wins if they do.
module exp_regfile #(
    parameter int NB = 8,
    parameter int PW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_load,
    input  logic [PW-1:0] ptr_din,
    input  logic          ptr_toggle,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic [15:0]   in_bytes,
    output logic [7:0]    rd_cur,
    output logic [7:0]    rd_alt,
    output logic [NB*8-1:0] store_o
);

    localparam int RO_BYTES = 2;

    logic [PW-1:0]   ptr_q;
    logic [NB*8-1:0] rd_vec;

    // Reset value of a stored byte: polarity pair clears, others set.
    function automatic logic [7:0] rst_byte(input int idx);
        return ((idx >> 1) == 2) ? 8'h00 : 8'hFF;
    endfunction

    // Pointer: command load has priority over the pair toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ptr_din;
        end else if (ptr_toggle) begin
            ptr_q <= ptr_q ^ PW'(1);
        end
    end

    for (genvar gi = 0; gi < NB; gi++) begin : g_byte
        if (gi < RO_BYTES) begin : g_ro
            assign rd_vec[gi*8 +: 8] = in_bytes[gi*8 +: 8];
        end else begin : g_rw
            logic [7:0] q;
            // Storage byte written when the pointer selects it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= rst_byte(gi);
                end else if (wr_en && ptr_q == PW'(gi)) begin
                    q <= wr_data;
                end
            end
            assign rd_vec[gi*8 +: 8] = q;
        end
    end

    assign rd_cur  = rd_vec[int'(ptr_q)*8 +: 8];
    assign rd_alt  = rd_vec[int'(ptr_q ^ PW'(1))*8 +: 8];
    assign store_o = rd_vec;

    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_toggle && !ptr_load) |=> (ptr_q == ($past(ptr_q) ^ PW'(1)))); // R3
    AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr_q < PW'(RO_BYTES)) |=> $stable(rd_vec[NB*8-1:RO_BYTES*8])); // R4

endmodule

// File: rtl/exp_link_fsm.sv
// Bit-level slave protocol: address match, command byte, write bytes,
// and read streaming with master acknowledge. Drives only the SDA
// enable. Assumes synchronized inputs and single-cycle edge flags.
module exp_link_fsm
    import exp_pkg::*;
#(
    parameter logic [3:0] ADDR_PREFIX = 4'b0100,
    parameter int         PW          = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [2:0]    strap,
    input  logic [7:0]    rd_cur,
    input  logic [7:0]    rd_alt,
    output logic          sda_oe,
    output logic          ptr_load,
    output logic [PW-1:0] ptr_din,
    output logic          ptr_toggle,
    output logic          wr_en,
    output logic [7:0]    wr_data
);

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    link_state_e state_q;
    logic [3:0]  bitcnt_q;
    logic [7:0]  rx_q;
    logic [7:0]  tx_q;
    logic        rw_q;
    logic        mack_q;
    logic        sda_oe_q;
    logic        byte_end;
    logic        addr_hit;

    // Strobes toward the register file, aligned with the closing SCL fall.
    always_comb begin
        byte_end   = scl_fall && (bitcnt_q == BITS_PER_BYTE);
        addr_hit   = (rx_q[7:1] == {ADDR_PREFIX, strap});
        ptr_load   = (state_q == S_CMD) && byte_end && !start_det && !stop_det;
        ptr_din    = rx_q[PW-1:0];
        wr_en      = (state_q == S_WDATA) && byte_end && !start_det && !stop_det;
        wr_data    = rx_q;
        ptr_toggle = wr_en ||
                     ((state_q == S_RACK) && scl_rise && !sda_s && !start_det && !stop_det);
    end

    // Protocol sequencer, shift registers and SDA enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            bitcnt_q <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (start_det) begin
            state_q  <= S_ADDR;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else if (stop_det) begin
            state_q  <= S_IDLE;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else begin
            case (state_q)
                S_ADDR, S_CMD, S_WDATA: begin
                    if (scl_rise) begin
                        rx_q     <= {rx_q[6:0], sda_s};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (byte_end) begin
                        bitcnt_q <= '0;
                        if (state_q == S_ADDR) begin
                            if (addr_hit) begin
                                rw_q     <= rx_q[0];
                                sda_oe_q <= 1'b1;
                                state_q  <= S_ADDR_ACK;
                            end else begin
                                state_q  <= S_IDLE;
                            end
                        end else begin
                            sda_oe_q <= 1'b1;
                            state_q  <= (state_q == S_CMD) ? S_CMD_ACK : S_WDATA_ACK;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_rise && rw_q) begin
                        tx_q <= rd_cur;
                    end else if (scl_fall) begin
                        bitcnt_q <= '0;
                        if (rw_q) begin
                            sda_oe_q <= ~tx_q[7];
                            state_q  <= S_RDATA;
                        end else begin
                            sda_oe_q <= 1'b0;
                            state_q  <= S_CMD;
                        end
                    end
                end
                S_CMD_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe_q <= 1'b0;
                        state_q  <= S_WDATA;
                    end
                end
                S_RDATA: begin
                    if (scl_rise) begin
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt_q == BITS_PER_BYTE) begin
                            sda_oe_q <= 1'b0;
                            bitcnt_q <= '0;
                            state_q  <= S_RACK;
                        end else begin
                            sda_oe_q <= ~tx_q[6];
                            tx_q     <= {tx_q[6:0], 1'b0};
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_s;
                        if (!sda_s) begin
                            tx_q <= rd_alt;
                        end
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            sda_oe_q <= ~tx_q[7];
                            state_q  <= S_RDATA;
                        end else begin
                            sda_oe_q <= 1'b0;
                            state_q  <= S_IDLE;
                        end
                    end
                end
                default: begin
                    sda_oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe = sda_oe_q;

    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= BITS_PER_BYTE); // R5
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !sda_oe_q); // R7
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == S_ADDR)); // R8
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_q != $past(sda_oe_q)) |-> !$past(scl_s)); // R1

endmodule

// File: rtl/i2c_pair_expander.sv
// Top of the register-pair expander: bus synchronizer, protocol
// sequencer and register file. Assumes clk oversamples SCL by at least
// eight and that SDA changes only while SCL is low except START/STOP.
module i2c_pair_expander #(
    parameter logic [3:0] ADDR_PREFIX = 4'b0100,
    parameter int         SYNC_STAGES = 2,
    parameter int         NUM_PAIRS   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_o,
    output logic        sda_oe,
    input  logic [2:0]  addr_strap,
    input  logic [7:0]  in_port0,
    input  logic [7:0]  in_port1,
    output logic [15:0] out_reg,
    output logic [15:0] pol_reg,
    output logic [15:0] cfg_reg
);

    localparam int NB = 2 * NUM_PAIRS;
    localparam int PW = $clog2(NB);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          ptr_load, ptr_toggle, wr_en;
    logic [PW-1:0] ptr_din;
    logic [7:0]    wr_data, rd_cur, rd_alt;
    logic [NB*8-1:0] store;

    exp_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    exp_link_fsm #(.ADDR_PREFIX(ADDR_PREFIX), .PW(PW)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .strap      (addr_strap),
        .rd_cur     (rd_cur),
        .rd_alt     (rd_alt),
        .sda_oe     (sda_oe),
        .ptr_load   (ptr_load),
        .ptr_din    (ptr_din),
        .ptr_toggle (ptr_toggle),
        .wr_en      (wr_en),
        .wr_data    (wr_data)
    );

    exp_regfile #(.NB(NB), .PW(PW)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_load   (ptr_load),
        .ptr_din    (ptr_din),
        .ptr_toggle (ptr_toggle),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .in_bytes   ({in_port1, in_port0}),
        .rd_cur     (rd_cur),
        .rd_alt     (rd_alt),
        .store_o    (store)
    );

    assign sda_o   = 1'b0;
    assign out_reg = store[16 +: 16];
    assign pol_reg = store[32 +: 16];
    assign cfg_reg = store[48 +: 16];

endmodule

// File: tb/test_i2c_pair_expander.sv
module test_i2c_pair_expander;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_o, sda_oe;
    logic [2:0]  strap = 3'b101;
    logic [7:0]  in0 = 8'h00, in1 = 8'h00;
    logic [15:0] out_reg, pol_reg, cfg_reg;

    int          total = 0, fails = 0, oe_cnt = 0;
    logic [7:0]  mdl [8];
    logic [2:0]  mptr = 3'd0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_pair_expander i_i2c_pair_expander (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .addr_strap(strap),
        .in_port0(in0), .in_port1(in1),
        .out_reg(out_reg), .pol_reg(pol_reg), .cfg_reg(cfg_reg)
    );

    always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] p);
        if (p == 3'd0) return in0;
        if (p == 3'd1) return in1;
        return mdl[p];
    endfunction

    task automatic check_regs(input string req);
        check(req, {16'h0, out_reg}, {16'h0, mdl[3], mdl[2]});
        check(req, {16'h0, pol_reg}, {16'h0, mdl[5], mdl[4]});
        check(req, {16'h0, cfg_reg}, {16'h0, mdl[7], mdl[6]});
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0; hold(2);
        end
        sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q/2);
        ack = !sda_line; hold(Q/2); scl_m = 1'b0; hold(2);
    endtask

    task automatic rbyte(input bit mack, input bit scramble, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(Q); scl_m = 1'b1; hold(Q/2);
            b[i] = sda_line;
            if (scramble && i == 7) begin in0 = ~in0; in1 = ~in1; end
            hold(Q/2); scl_m = 1'b0; hold(2);
        end
        sda_m = !mack; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0; hold(2);
        sda_m = 1'b1;
    endtask

    // Write transfer with model update; hit selects whether the address matches.
    task automatic do_write(input bit hit, input logic [7:0] cmd, input int n, input logic [7:0] d [8]);
        bit ack;
        int oe0;
        oe0 = oe_cnt;
        bus_start();
        wbyte({4'b0100, hit ? strap : ~strap, 1'b0}, ack);
        check("R1 address ack", {31'h0, ack}, {31'h0, hit});
        wbyte(cmd, ack);
        if (hit) begin
            check("R2 command ack", {31'h0, ack}, 32'h1);
            mptr = cmd[2:0];
        end
        for (int k = 0; k < n; k++) begin
            wbyte(d[k], ack);
            if (hit) begin
                check("R3 data ack", {31'h0, ack}, 32'h1);
                if (mptr >= 3'd2) mdl[mptr] = d[k];
                mptr = mptr ^ 3'd1;
            end
        end
        bus_stop();
        if (!hit) check("R1 no drive on mismatch", oe_cnt, oe0);
        check_regs("R3 R4 registers after write");
    endtask

    // Read with optional command byte; each byte compared with the model.
    task automatic do_read(input bit with_cmd, input logic [7:0] cmd, input int n,
                           input bit scramble, input bit end_stop, input string req);
        bit ack;
        logic [7:0] got, exp;
        bus_start();
        if (with_cmd) begin
            wbyte({4'b0100, strap, 1'b0}, ack);
            wbyte(cmd, ack);
            mptr = cmd[2:0];
            bus_start();
        end
        wbyte({4'b0100, strap, 1'b1}, ack);
        check("R1 read address ack", {31'h0, ack}, 32'h1);
        for (int k = 0; k < n; k++) begin
            exp = exp_rd(mptr);
            rbyte(k != n - 1, scramble && k == 0, got);
            check(req, {24'h0, got}, {24'h0, exp});
            if (k != n - 1) mptr = mptr ^ 3'd1;
        end
        if (end_stop) bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] d [8];
        bit ack;
        int oe0;
        mdl[0] = 8'h00; mdl[1] = 8'h00;
        mdl[2] = 8'hFF; mdl[3] = 8'hFF; mdl[4] = 8'h00; mdl[5] = 8'h00;
        mdl[6] = 8'hFF; mdl[7] = 8'hFF;
        void'($urandom(32'd7321));
        hold(5); rst_n = 1'b1; hold(5);

        // R10 reset state
        check("R10 reset regs", {out_reg, pol_reg}, 32'hFFFF_0000);
        check("R10 reset cfg", {16'h0, cfg_reg}, 32'h0000_FFFF);
        check("R10 reset sda", {31'h0, sda_oe}, 32'h0);

        // R1 wrong address: nothing acked, nothing written
        d[0] = 8'h12; d[1] = 8'h34;
        do_write(1'b0, 8'h02, 2, d);

        // R3 three bytes from pointer 2: 2, 3, 2
        d[0] = 8'hAA; d[1] = 8'h55; d[2] = 8'h3C;
        do_write(1'b1, 8'h02, 3, d);
        check("R3 out pair", {16'h0, out_reg}, 32'h553C);

        // R2 upper command bits ignored: 0xF4 selects polarity low
        d[0] = 8'h81;
        do_write(1'b1, 8'hF4, 1, d);
        check("R2 pol low", {16'h0, pol_reg}, 32'h0081);

        // R3 odd start pointer: 7 then 6
        d[0] = 8'h9E; d[1] = 8'h61;
        do_write(1'b1, 8'h07, 2, d);
        check("R3 cfg pair", {16'h0, cfg_reg}, 32'h9E61);

        // R4 writes to input ports ignored
        d[0] = 8'h77; d[1] = 8'h66;
        do_write(1'b1, 8'h00, 2, d);
        in0 = 8'h19; in1 = 8'hE4;
        do_read(1'b1, 8'h00, 2, 1'b0, 1'b1, "R4 input ports read pins");

        // R5 long alternating read from 7
        do_read(1'b1, 8'h07, 5, 1'b0, 1'b1, "R5 alternating read");

        // R6 pins captured at ack rising edge, changed mid-byte
        in0 = 8'h5A; in1 = 8'hC3;
        do_read(1'b1, 8'h00, 2, 1'b1, 1'b1, "R6 input capture");

        // R8 read 7,6 then repeated start: next read from 6
        do_read(1'b1, 8'h07, 2, 1'b0, 1'b0, "R8 first read");
        do_read(1'b0, 8'h00, 1, 1'b0, 1'b0, "R8 read after restart");

        // R7 after NACK the block ignores clocks until START
        oe0 = oe_cnt;
        wbyte({4'b0100, strap, 1'b1}, ack);
        check("R7 no ack after nack", {31'h0, ack}, 32'h0);
        check("R7 sda released", oe_cnt, oe0);
        bus_stop();

        // R9 STOP inside second data byte keeps first byte only
        bus_start();
        wbyte({4'b0100, strap, 1'b0}, ack);
        wbyte(8'h06, ack);
        wbyte(8'h42, ack);
        check("R9 first byte ack", {31'h0, ack}, 32'h1);
        mdl[6] = 8'h42; mptr = 3'd7;
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0; hold(2);
        end
        bus_stop();
        check_regs("R9 stop mid byte");

        // Random transfers against the model
        for (int it = 0; it < 30; it++) begin
            int n;
            logic [7:0] cmd;
            n = 1 + int'($urandom % 4);
            cmd = 8'($urandom);
            for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
            in0 = 8'($urandom); in1 = 8'($urandom);
            case ($urandom % 6)
                0: do_write(1'b0, cmd, n, d);
                1, 2, 3: do_write(1'b1, cmd, n, d);
                default: do_read(1'b1, cmd, n, 1'b0, 1'b1, "R5 random read");
            endcase
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule